// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a byte-oriented two-wire bus slave that holds the configuration of a receiver front end. Twelve writable configuration bytes drive the rest of the chip as one flat parallel bus, and two read-only status bytes are assembled from parallel status inputs. A system clock at least eight times the bus clock rate oversamples the bus lines after a two-flop synchronizer. The slave pulls SDA low through an open-drain enable and never stretches the clock.

A host selects one of two 7-bit device addresses with a strap pin. To write, it sends the device address, a register pointer and then any number of data bytes; the pointer advances after every data byte. To read, it first writes the pointer, then issues a repeated START with the read address and clocks bytes out. It acknowledges each byte to continue and sends a not-acknowledge to finish. One status bit reports that a reset has happened. That bit stays set until the host reads the first status byte in a transfer that is then closed by STOP.

The controller moves through nine named states. IDLE waits for a START. DEVADDR shifts in the address byte: a match goes to DEVACK and a mismatch returns to IDLE. DEVACK goes to RDATA for a read or to PTR for a write. PTR shifts in the pointer and goes to PTRACK, which goes on to WDATA. WDATA shifts in a data byte, commits it and goes to WACK, which returns to WDATA. RDATA shifts a byte out and goes to RACK. RACK returns to RDATA on a host acknowledge and to IDLE on a not-acknowledge. A STOP from any state forces IDLE, and a START from any state forces DEVADDR.

Top module: `serial_cfg_slave`

## Requirements
- R1: The device address is 7'b1100000 when `addr_sel` is 0 and 7'b1100001 when it is 1, so the write/read bytes are 0xC0/0xC1 or 0xC2/0xC3. On a match the slave pulls SDA low in the ninth clock. On a mismatch it acknowledges nothing, and no byte of that transfer changes any register.
- R2: In a write the first byte after the address is the register pointer. Each following data byte (MSB first) is acknowledged and stored at the pointer, and the pointer then advances by one.
- R3: The pointer advances from 0x0D to 0x00, for writes and for reads alike.
- R4: Bytes written to pointers 0x0C to 0x0F are acknowledged but change no register.
- R5: A read is a pointer write, then a repeated START with the read address. The slave drives the byte at the pointer MSB first. A host acknowledge moves on to the next register, and a host not-acknowledge releases SDA and ends the transfer.
- R6: Pointer 0x0C reads {reset_flag, stat_a_in[6:0]}, pointer 0x0D reads stat_b_in, and pointers 0x0E and 0x0F read 0x00.
- R7: reset_flag is 1 after reset. It clears only at a STOP that closes a transfer in which byte 0x0C was loaded for reading. Reading other bytes, or a repeated START, leaves it set, and nothing sets it again except reset.
- R8: After reset the configuration bytes 0x00..0x0B hold 03, B6, 00, 00, 00, 04, E0, CC, 4B, 00, 00, 00. Byte n sits at cfg_bus[8n+7:8n].
- R9: A STOP in any state returns the slave to IDLE with SDA released, and a START in any state restarts address reception. A byte cut off by either is discarded.
- R10: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 1 | Strap selecting the device address LSB |
| stat_a_in | input | 7 | Low seven bits of status byte 0x0C |
| stat_b_in | input | 8 | Status byte 0x0D |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_bus | output | 96 | Twelve configuration bytes, byte n at bits 8n+7:8n |

## Verification
The bench goes after the pointer wrap from 0x0B through the read-only bytes to 0x00. A design that stored into a status address, or wrapped at 0x0F, would corrupt byte 0x01 or leave 0x00 unchanged. It reads status byte 0x0C twice inside one transfer across a not-acknowledge and a repeated START, and then once more after STOP. Clearing the reset flag early or never shows up as a wrong bit 7. It also cuts bytes off with STOP and with START in mid-shift, and swaps the address strap. A slave that committed partial bytes, failed to resynchronize, or answered the wrong address would change a configuration byte or acknowledge when it should not.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_DEVACK,
        S_PTR,
        S_PTRACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK
    } slv_state_t;

    // Power-up contents of the writable bytes
    function automatic logic [7:0] cfg_reset_value(input int idx);
        case (idx)
            0:       return 8'h03;
            1:       return 8'hB6;
            5:       return 8'h04;
            6:       return 8'hE0;
            7:       return 8'hCC;
            8:       return 8'h4B;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfg_slave_pkg::*;
#(
    parameter int NWR = 12,
    parameter int DW  = 8,
    parameter int PW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     ptr,
    input  logic [DW-1:0]     wr_data,
    input  logic              flag_clr,
    input  logic [DW-2:0]     stat_a,
    input  logic [DW-1:0]     stat_b,
    output logic [NWR*DW-1:0] cfg_flat,
    output logic [DW-1:0]     rd_data,
    output logic              reset_flag
);
    logic [DW-1:0] regs [NWR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWR; i++) regs[i] <= DW'(cfg_reset_value(i));
            reset_flag <= 1'b1;
        end else begin
            for (int i = 0; i < NWR; i++)
                if (wr_en && ptr == PW'(i)) regs[i] <= wr_data;
            if (flag_clr) reset_flag <= 1'b0;
        end
    end

    for (genvar g = 0; g < NWR; g++) begin : g_flat
        assign cfg_flat[g*DW +: DW] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NWR; i++)
            if (ptr == PW'(i)) rd_data = regs[i];
        if (ptr == PW'(NWR))     rd_data = {reset_flag, stat_a};
        if (ptr == PW'(NWR + 1)) rd_data = stat_b;
    end
endmodule

// File: rtl/bus_slave_fsm.sv
module bus_slave_fsm
    import cfg_slave_pkg::*;
#(
    parameter int NWR = 12,
    parameter int DW  = 8,
    parameter int PW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [6:0]    dev_addr,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [PW-1:0] ptr,
    output logic [DW-1:0] wr_data,
    output logic          flag_clr
);
    localparam int NREG = NWR + 2;

    slv_state_t    state, nxt;
    logic [3:0]    bit_cnt;
    logic [DW-1:0] shreg;
    logic          rw, mack, stat_seen;
    logic          full;

    assign full = (bit_cnt == 4'd8);

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        nxt = state;
        if (stop_det)       nxt = S_IDLE;
        else if (start_det) nxt = S_DEVADDR;
        else begin
            unique case (state)
                S_IDLE:    nxt = S_IDLE;
                S_DEVADDR: if (scl_fall && full) nxt = (shreg[7:1] == dev_addr) ? S_DEVACK : S_IDLE;
                S_DEVACK:  if (scl_fall) nxt = rw ? S_RDATA : S_PTR;
                S_PTR:     if (scl_fall && full) nxt = S_PTRACK;
                S_PTRACK:  if (scl_fall) nxt = S_WDATA;
                S_WDATA:   if (scl_fall && full) nxt = S_WACK;
                S_WACK:    if (scl_fall) nxt = S_WDATA;
                S_RDATA:   if (scl_fall && bit_cnt == 4'd7) nxt = S_RACK;
                S_RACK:    if (scl_fall) nxt = mack ? S_IDLE : S_RDATA;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            mack      <= 1'b1;
            stat_seen <= 1'b0;
        end else if (stop_det || start_det) begin
            bit_cnt <= '0;
            if (stop_det) stat_seen <= 1'b0;
        end else begin
            unique case (state)
                S_DEVADDR, S_PTR, S_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && full) begin
                        bit_cnt <= '0;
                        if (state == S_DEVADDR) rw  <= shreg[0];
                        if (state == S_PTR)     ptr <= shreg[PW-1:0];
                        if (state == S_WDATA)   ptr <= ptr_next(ptr);
                    end
                end
                S_DEVACK, S_RACK: begin
                    if (state == S_RACK && scl_rise) mack <= sda_lvl;
                    if (scl_fall && ((state == S_DEVACK && rw) || (state == S_RACK && !mack))) begin
                        shreg   <= rd_data;
                        bit_cnt <= '0;
                        ptr     <= ptr_next(ptr);
                        if (ptr == PW'(NWR)) stat_seen <= 1'b1;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) bit_cnt <= '0;
                        else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            shreg   <= {shreg[DW-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            S_DEVACK, S_PTRACK, S_WACK: sda_oe = 1'b1;
            S_RDATA:                    sda_oe = ~shreg[DW-1];
            default:                    sda_oe = 1'b0;
        endcase
        wr_en    = (state == S_WDATA) && scl_fall && full && !start_det && !stop_det;
        wr_data  = shreg;
        flag_clr = stop_det && stat_seen;
    end
endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave #(
    parameter int         DW          = 8,
    parameter int         NWR         = 12,
    parameter logic [6:0] BASE_ADDR   = 7'h60,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    input  logic [DW-2:0]     stat_a_in,
    input  logic [DW-1:0]     stat_b_in,
    output logic              sda_oe,
    output logic [NWR*DW-1:0] cfg_bus
);
    localparam int PW = $clog2(NWR + 4);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en, flag_clr, por_flag;
    logic [PW-1:0] ptr;
    logic [DW-1:0] wr_data, rd_data;
    logic [6:0]    dev_addr;

    assign dev_addr = {BASE_ADDR[6:1], BASE_ADDR[0] | addr_sel};

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    bus_slave_fsm #(.NWR(NWR), .DW(DW), .PW(PW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .ptr(ptr), .wr_data(wr_data), .flag_clr(flag_clr)
    );

    cfg_store #(.NWR(NWR), .DW(DW), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
        .flag_clr(flag_clr), .stat_a(stat_a_in), .stat_b(stat_b_in),
        .cfg_flat(cfg_bus), .rd_data(rd_data), .reset_flag(por_flag)
    );
endmodule

// File: rtl/serial_cfg_slave_chk.sv
module serial_cfg_slave_chk #(
    parameter int W = 96
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sda_oe,
    input logic         scl_s,
    input logic         stop_det,
    input logic         wr_en,
    input logic         por_flag,
    input logic [W-1:0] cfg_bus
);
    // R10: drive changes only while synchronized SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9: a STOP releases the line
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R7: the reset flag falls only right after a STOP
    a_r7_flag_clears_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(stop_det));

    // R7: once clear, the flag stays clear
    a_r7_flag_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !por_flag |=> !por_flag);

    // R4: configuration changes only through a committed write
    a_r4_cfg_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bus) |-> $past(wr_en));
endmodule

bind serial_cfg_slave serial_cfg_slave_chk #(.W(NWR*DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .stop_det(stop_det), .wr_en(wr_en), .por_flag(por_flag), .cfg_bus(cfg_bus)
);

// File: tb/tb_serial_cfg_slave.sv
module tb_serial_cfg_slave;
    localparam int H = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic [6:0] stat_a = 7'h35;
    logic [7:0] stat_b = 8'hA6;
    logic sda_oe;
    logic [95:0] cfg_bus;
    wire sda_line = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    serial_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .addr_sel(addr_sel), .stat_a_in(stat_a), .stat_b_in(stat_b),
        .sda_oe(sda_oe), .cfg_bus(cfg_bus)
    );

    typedef struct { string tag; int val; } item_t;
    item_t exp_q[$];
    int    act_q[$];
    int    n_vec = 0, n_bad = 0, r10_bad = 0;
    bit    done = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    // Scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t e; int a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_vec++;
            if (a != e.val) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", e.tag, a, e.val);
            end
        end
    end

    // R10 port-level watch: drive must not move while SCL is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && m_scl) r10_bad++;
        oe_prev <= sda_oe;
    end

    task automatic check(input string tag, input int exp, input int act);
        item_t e;
        e.tag = tag; e.val = exp;
        exp_q.push_back(e);
        act_q.push_back(act);
    endtask

    task automatic hw(); repeat (H) @(negedge clk); endtask
    task automatic lo(); m_scl = 1'b0; repeat (2) @(negedge clk); endtask

    task automatic bstart();
        m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); lo(); hw();
    endtask

    task automatic bstop();
        m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw();
    endtask

    task automatic tx(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw(); m_scl = 1'b1; hw(); lo();
        end
        m_sda = 1'b1; hw(); m_scl = 1'b1; hw();
        acked = ~sda_line;
        lo();
    endtask

    task automatic txbits(input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); lo();
        end
    endtask

    task automatic rx(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(); m_scl = 1'b1; hw(); b[i] = sda_line; lo();
        end
        m_sda = ~give_ack; hw(); m_scl = 1'b1; hw(); lo(); m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                            input bit exp_ack, input string tag);
        bit a;
        bstart();
        tx(dev, a); check({tag, " addr ack"}, exp_ack, a);
        tx(ptr, a); check({tag, " ptr ack"}, exp_ack, a);
        for (int i = 0; i < n; i++) begin
            tx(wbuf[i], a); check({tag, " data ack"}, exp_ack, a);
        end
        bstop();
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                           input bit with_stop);
        bit a;
        bstart();
        tx(dev, a); tx(ptr, a);
        bstart();
        tx(dev | 8'h01, a); check("R5 read addr ack", 1, a);
        for (int i = 0; i < n; i++) rx(i < n - 1, rbuf[i]);
        if (with_stop) bstop();
    endtask

    task automatic chk_cfg(input int idx, input logic [7:0] exp, input string tag);
        check(tag, exp, cfg_bus[idx*8 +: 8]);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] dflt [12] = '{8'h03, 8'hB6, 8'h00, 8'h00, 8'h00, 8'h04,
                                  8'hE0, 8'hCC, 8'h4B, 8'h00, 8'h00, 8'h00};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8 reset defaults
        for (int i = 0; i < 12; i++) chk_cfg(i, dflt[i], "R8 default");
        check("R9 idle release", 0, sda_oe);

        // R1 wrong address ignored
        bstart();
        tx(8'hC2, a); check("R1 mismatch nack", 0, a);
        tx(8'h00, a); tx(8'hEE, a); check("R1 mismatch data nack", 0, a);
        bstop();
        chk_cfg(0, 8'h03, "R1 mismatch no write");

        // R2 burst write
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(8'hC0, 8'h00, 3, 1, "R2");
        chk_cfg(0, 8'h11, "R2 byte0");
        chk_cfg(1, 8'h22, "R2 byte1");
        chk_cfg(2, 8'h33, "R2 byte2");

        // R3/R4 wrap through read-only bytes
        wbuf[0] = 8'h5A; wbuf[1] = 8'h77; wbuf[2] = 8'h88; wbuf[3] = 8'h99;
        do_write(8'hC0, 8'h0B, 4, 1, "R4");
        chk_cfg(11, 8'h5A, "R3 byte11");
        chk_cfg(0, 8'h99, "R3 wrap to 0");
        chk_cfg(1, 8'h22, "R3 byte1 untouched");

        // R5 single read
        do_read(8'hC0, 8'h05, 1, 1);
        check("R5 read 0x05", 8'h04, rbuf[0]);
        check("R5 released after nack", 0, sda_oe);

        // R5/R6 burst read across status bytes, R7 flag still set
        do_read(8'hC0, 8'h0A, 4, 0);
        check("R5 read 0x0A", 8'h00, rbuf[0]);
        check("R5 read 0x0B", 8'h5A, rbuf[1]);
        check("R6 R7 status0 flag set", 8'hB5, rbuf[2]);
        check("R6 status1", 8'hA6, rbuf[3]);
        do_read(8'hC0, 8'h0C, 1, 1);
        check("R7 held over repeated start", 8'hB5, rbuf[0]);

        // R7 cleared after STOP; R3 read wrap
        do_read(8'hC0, 8'h0C, 1, 1);
        check("R7 flag cleared", 8'h35, rbuf[0]);
        do_read(8'hC0, 8'h0D, 3, 1);
        check("R3 read 0x0D", 8'hA6, rbuf[0]);
        check("R3 read wrap 0x00", 8'h99, rbuf[1]);
        check("R3 read 0x01", 8'h22, rbuf[2]);
        do_read(8'hC0, 8'h0E, 1, 1);
        check("R6 unused pointer reads 0", 8'h00, rbuf[0]);

        // R9 STOP mid-byte
        bstart(); tx(8'hC0, a); tx(8'h04, a); txbits(4); bstop();
        chk_cfg(4, 8'h00, "R9 stop discards partial");
        check("R9 stop release", 0, sda_oe);
        wbuf[0] = 8'h44;
        do_write(8'hC0, 8'h04, 1, 1, "R9 recover");
        chk_cfg(4, 8'h44, "R9 write after abort");

        // R9 START mid-byte
        bstart(); tx(8'hC0, a); tx(8'h06, a); txbits(3);
        bstart(); tx(8'hC0, a); check("R9 restart ack", 1, a);
        tx(8'h07, a); tx(8'h12, a); bstop();
        chk_cfg(6, 8'hE0, "R9 start discards partial");
        chk_cfg(7, 8'h12, "R9 write after restart");

        // R1 strap high
        addr_sel = 1'b1;
        repeat (4) @(negedge clk);
        wbuf[0] = 8'hAB;
        do_write(8'hC2, 8'h03, 1, 1, "R1 strap high");
        chk_cfg(3, 8'hAB, "R1 strap high write");
        wbuf[0] = 8'hCD;
        do_write(8'hC0, 8'h03, 1, 0, "R1 old address");
        chk_cfg(3, 8'hAB, "R1 old address ignored");

        check("R10 drive moved with SCL high", 0, r10_bad);

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule